// File: doc/BRIEF.md
# Self-Timed Program Cycle and Write Guard

This block sits behind a serial EEPROM's command decoder and owns the internal program cycle. The decoder signals two points in a write command: the clock edge that captures the first data bit, and the STOP that ends the command. On that STOP the guard decides whether the write may proceed. It considers the supply-low flag, a one-time lower-half protection bit and the write-protect pin. An accepted write runs a program cycle of fixed length, counted in clock ticks. During that cycle the block issues one array write strobe per buffered byte, and it ignores any new command.

The write-protect pin has no effect until the first data bit is captured. From that edge until the program cycle ends, a high level aborts the write at once. The block then drops back to standby and sets a sticky cancel flag, which marks the array contents as untrustworthy. A separate one-shot command sets the protection bit. After that, any write to the lower half of the array is refused without a program cycle. The cycle length must be at least the page size, so that every strobe fits inside it.

Top module: `wcg_top`

## Requirements
- R1: An accepted write raises `busy` in the cycle after the clock edge that samples `wr_req`, and `busy` stays high for exactly CYCLE_TICKS cycles unless it is aborted.
- R2: An accepted write gives one `arr_we` strobe per byte, on consecutive cycles starting with the first busy cycle. The address is `{wr_page, offset}`, where the offset starts at `wr_first` and wraps modulo PAGE_BYTES inside the page.
- R3: A byte count above PAGE_BYTES gives exactly PAGE_BYTES strobes, beginning at `wr_first`.
- R4: If `wp_pin` is high at the `d0_capture` edge, or at any edge between `d0_capture` and `wr_req`, the write is cancelled. There is then no busy cycle and no strobe, and `cancel_flag` is set.
- R5: If `wp_pin` is high at an edge while `busy` is high, `busy` falls after that edge, no further strobes follow, and `cancel_flag` is set.
- R6: A high level on `wp_pin` before the `d0_capture` edge has no effect on the write.
- R7: While `vcc_low` is high, a write that ends is dropped: no busy cycle, no strobe. A protection command is not acknowledged.
- R8: An accepted protection command pulses `lock_ack` and raises `protect_set` one cycle after it is sampled. From then on, writes to pages whose top bit is 0 (addresses below half the array) are dropped, and writes to the upper half still run.
- R9: Once `protect_set` is high it stays high. Any later protection command gets no `lock_ack`.
- R10: While `busy` is high, `d0_capture`, `wr_req` and `lock_req` are ignored.
- R11: `cancel_flag` stays set until reset or until the next accepted write starts, and it reads 0 in that write's first busy cycle.
- R12: After reset, `busy`, `arr_we`, `cancel_flag`, `protect_set` and `lock_ack` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| d0_capture | input | 1 | Pulse on the edge that captures the first data bit |
| wr_req | input | 1 | Pulse on the STOP that ends a write command |
| wr_page | input | ADDR_W-log2(PAGE_BYTES) | Page number of the write |
| wr_first | input | log2(PAGE_BYTES) | Offset of the first byte within the page |
| wr_count | input | log2(PAGE_BYTES)+1 | Number of bytes received |
| wp_pin | input | 1 | Write-protect pin level |
| vcc_low | input | 1 | Supply below the safe write level |
| lock_req | input | 1 | Pulse: command to set the lower-half protection bit |
| busy | output | 1 | Program cycle in progress |
| arr_we | output | 1 | Array write strobe for one byte |
| arr_addr | output | ADDR_W | Array address of the strobed byte |
| cancel_flag | output | 1 | Sticky: last write was aborted by the protect pin |
| protect_set | output | 1 | Lower-half protection bit |
| lock_ack | output | 1 | One-cycle acknowledge of the protection command |

## Verification
A controller that misses the armed state, or leaves it, shows up one cycle after the STOP pulse. Either `busy` fails to rise for a write that should run, or it rises for one that should have been cancelled. An off-by-one in the tick counter first appears on the falling edge of `busy`, CYCLE_TICKS cycles later. A wrong strobe index or wrong wrap logic shows on `arr_addr` at the very strobe where it happens. A late abort shows as one strobe too many, or as `busy` still high in the cycle after `wp_pin` was sampled.

// File: rtl/wcg_pkg.sv
package wcg_pkg;

    typedef enum logic [1:0] {
        WS_IDLE  = 2'd0,
        WS_ARMED = 2'd1,
        WS_PROG  = 2'd2
    } wstate_e;

    typedef enum logic [1:0] {
        WV_GO    = 2'd0,
        WV_LOWV  = 2'd1,
        WV_PROT  = 2'd2,
        WV_EMPTY = 2'd3
    } verdict_e;

    // Decide at STOP whether the buffered write may run.
    function automatic verdict_e judge(input logic low, input logic prot_on,
                                       input logic lower_half, input logic empty);
        if (low)
            return WV_LOWV;
        if (empty)
            return WV_EMPTY;
        if (prot_on && lower_half)
            return WV_PROT;
        return WV_GO;
    endfunction

endpackage

// File: rtl/wcg_timer.sv
module wcg_timer #(
    parameter int CYCLE_TICKS = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic last
);
    localparam int CW = $clog2(CYCLE_TICKS + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (start)
            cnt <= CW'(CYCLE_TICKS - 1);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign last = (cnt == '0);

endmodule

// File: rtl/wcg_strobe.sv
module wcg_strobe #(
    parameter int ADDR_W     = 8,
    parameter int PAGE_BYTES = 16,
    localparam int OFF_W     = $clog2(PAGE_BYTES),
    localparam int PAGE_W    = ADDR_W - OFF_W,
    localparam int CNT_W     = OFF_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              active,
    input  logic [PAGE_W-1:0] page,
    input  logic [OFF_W-1:0]  first,
    input  logic [CNT_W-1:0]  nbytes,
    output logic              we,
    output logic [ADDR_W-1:0] addr
);
    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic [OFF_W-1:0]  first;
        logic [CNT_W-1:0]  nb;
    } job_t;

    job_t             job;
    logic [CNT_W-1:0] idx;
    logic [OFF_W-1:0] off_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            job <= '0;
            idx <= '0;
        end else if (start) begin
            job <= '{page: page, first: first, nb: nbytes};
            idx <= '0;
        end else if (active && (idx < job.nb)) begin
            idx <= idx + 1'b1;
        end
    end

    assign off_now = job.first + idx[OFF_W-1:0];
    assign we      = active && (idx < job.nb);
    assign addr    = {job.page, off_now};

    // R2: back-to-back strobes walk the offset by one inside a fixed page
    assert_offset_walk_R2: assert property (@(posedge clk) disable iff (rst)
        (we && $past(we)) |->
            ((addr[OFF_W-1:0] == $past(addr[OFF_W-1:0]) + 1'b1) &&
             (addr[ADDR_W-1:OFF_W] == $past(addr[ADDR_W-1:OFF_W]))));

endmodule

// File: rtl/wcg_lock.sv
module wcg_lock (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic allow,
    output logic prot,
    output logic ack
);
    always_ff @(posedge clk) begin
        if (rst) begin
            prot <= 1'b0;
            ack  <= 1'b0;
        end else begin
            ack <= 1'b0;
            if (req && allow && !prot) begin
                prot <= 1'b1;
                ack  <= 1'b1;
            end
        end
    end

    // R9: the protection bit never clears
    assert_lock_keep_R9: assert property (@(posedge clk) disable iff (rst)
        prot |=> prot);

    // R9: an acknowledge only accompanies the first setting
    assert_ack_first_R9: assert property (@(posedge clk) disable iff (rst)
        ack |-> $rose(prot));

endmodule

// File: rtl/wcg_top.sv
module wcg_top #(
    parameter int ADDR_W      = 8,
    parameter int PAGE_BYTES  = 16,
    parameter int CYCLE_TICKS = 40,
    localparam int OFF_W      = $clog2(PAGE_BYTES),
    localparam int PAGE_W     = ADDR_W - OFF_W,
    localparam int CNT_W      = OFF_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              d0_capture,
    input  logic              wr_req,
    input  logic [PAGE_W-1:0] wr_page,
    input  logic [OFF_W-1:0]  wr_first,
    input  logic [CNT_W-1:0]  wr_count,
    input  logic              wp_pin,
    input  logic              vcc_low,
    input  logic              lock_req,
    output logic              busy,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic              cancel_flag,
    output logic              protect_set,
    output logic              lock_ack
);
    import wcg_pkg::*;

    localparam int RUN_W = $clog2(CYCLE_TICKS + 1);

    wstate_e          st;
    verdict_e         verdict;
    logic             start;
    logic             tick_last;
    logic [CNT_W-1:0] nb_clamped;
    logic [RUN_W-1:0] run;

    assign verdict    = judge(vcc_low, protect_set, ~wr_page[PAGE_W-1], wr_count == '0);
    assign nb_clamped = (wr_count > CNT_W'(PAGE_BYTES)) ? CNT_W'(PAGE_BYTES) : wr_count;
    assign start      = (st == WS_ARMED) && !wp_pin && wr_req && (verdict == WV_GO);
    assign busy       = (st == WS_PROG);

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= WS_IDLE;
            cancel_flag <= 1'b0;
        end else begin
            unique case (st)
                WS_IDLE: begin
                    if (d0_capture) begin
                        if (wp_pin)
                            cancel_flag <= 1'b1;
                        else
                            st <= WS_ARMED;
                    end
                end
                WS_ARMED: begin
                    if (wp_pin) begin
                        st          <= WS_IDLE;
                        cancel_flag <= 1'b1;
                    end else if (wr_req) begin
                        if (verdict == WV_GO) begin
                            st          <= WS_PROG;
                            cancel_flag <= 1'b0;
                        end else begin
                            st <= WS_IDLE;
                        end
                    end
                end
                WS_PROG: begin
                    if (wp_pin) begin
                        st          <= WS_IDLE;
                        cancel_flag <= 1'b1;
                    end else if (tick_last) begin
                        st <= WS_IDLE;
                    end
                end
                default: st <= WS_IDLE;
            endcase
        end
    end

    wcg_timer #(.CYCLE_TICKS(CYCLE_TICKS)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .last  (tick_last)
    );

    wcg_strobe #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_strobe (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .active (busy),
        .page   (wr_page),
        .first  (wr_first),
        .nbytes (nb_clamped),
        .we     (arr_we),
        .addr   (arr_addr)
    );

    wcg_lock u_lock (
        .clk   (clk),
        .rst   (rst),
        .req   (lock_req),
        .allow ((st == WS_IDLE) && !vcc_low),
        .prot  (protect_set),
        .ack   (lock_ack)
    );

    // Length of the current busy run, watched by the cycle-length checks.
    always_ff @(posedge clk) begin
        if (rst || !busy)
            run <= '0;
        else
            run <= run + 1'b1;
    end

    // R1: a program cycle never outlasts its tick budget
    assert_busy_cap_R1: assert property (@(posedge clk) disable iff (rst)
        busy |-> (run < RUN_W'(CYCLE_TICKS)));

    // R1: a cycle not cut by the pin lasts the full budget
    assert_busy_full_R1: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && !$past(wp_pin)) |-> ($past(run) == RUN_W'(CYCLE_TICKS - 1)));

    // R2: strobes only appear inside a program cycle
    assert_strobe_in_cycle_R2: assert property (@(posedge clk) disable iff (rst)
        arr_we |-> busy);

    // R5: the pin ends a running cycle on the next edge
    assert_wp_abort_R5: assert property (@(posedge clk) disable iff (rst)
        (busy && wp_pin) |=> !busy);

    // R4: the cancel flag only rises because of the pin
    assert_cancel_cause_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(cancel_flag) |-> $past(wp_pin));

    // R7: no cycle can start on a low supply
    assert_low_supply_R7: assert property (@(posedge clk) disable iff (rst)
        (!busy && vcc_low) |=> !busy);

    // R8: protected region never receives a strobe
    assert_prot_region_R8: assert property (@(posedge clk) disable iff (rst)
        (arr_we && protect_set) |-> arr_addr[ADDR_W-1]);

    // R10: a protection command during a cycle is never acknowledged
    assert_busy_no_ack_R10: assert property (@(posedge clk) disable iff (rst)
        busy |=> !lock_ack);

    // R11: an accepted write clears the sticky flag
    assert_cancel_clear_R11: assert property (@(posedge clk) disable iff (rst)
        start |=> !cancel_flag);

endmodule

// File: tb/tb_wcg_top.sv
module tb_wcg_top;

    localparam int CT = 40;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       d0_capture = 1'b0;
    logic       wr_req = 1'b0;
    logic [3:0] wr_page = '0;
    logic [3:0] wr_first = '0;
    logic [4:0] wr_count = '0;
    logic       wp_pin = 1'b0;
    logic       vcc_low = 1'b0;
    logic       lock_req = 1'b0;
    logic       busy, arr_we, cancel_flag, protect_set, lock_ack;
    logic [7:0] arr_addr;

    int   checks = 0;
    int   errs = 0;
    int   ack_seen = 0;
    bit   done = 1'b0;
    logic [7:0] exp_q[$];

    always #10 clk = ~clk;

    wcg_top #(.ADDR_W(8), .PAGE_BYTES(16), .CYCLE_TICKS(CT)) dut (
        .clk(clk), .rst(rst), .d0_capture(d0_capture), .wr_req(wr_req),
        .wr_page(wr_page), .wr_first(wr_first), .wr_count(wr_count),
        .wp_pin(wp_pin), .vcc_low(vcc_low), .lock_req(lock_req),
        .busy(busy), .arr_we(arr_we), .arr_addr(arr_addr),
        .cancel_flag(cancel_flag), .protect_set(protect_set), .lock_ack(lock_ack)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: every strobe is compared against the scoreboard queue (R2, R3)
    always @(negedge clk) begin
        if (!rst) begin
            if (lock_ack) ack_seen++;
            if (arr_we) begin
                checks++;
                if (exp_q.size() == 0) begin
                    errs++;
                    $display("FAIL R2 unexpected strobe actual=%0h expected=none", arr_addr);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    if (arr_addr !== e) begin
                        errs++;
                        $display("FAIL R2 strobe address actual=%0h expected=%0h", arr_addr, e);
                    end
                end
            end
        end
    end

    function automatic logic [7:0] eaddr(input int pg, input int f, input int i);
        return {4'(pg), 4'(f + i)};
    endfunction

    task automatic measure(output int n);
        n = 0;
        for (int k = 0; k < 4 * CT; k++) begin
            @(negedge clk);
            if (busy) n++;
            else break;
        end
    endtask

    task automatic pulse_d0();
        @(posedge clk); #1 d0_capture = 1'b1;
        @(posedge clk); #1 d0_capture = 1'b0;
    endtask

    task automatic pulse_lock();
        @(posedge clk); #1 lock_req = 1'b1;
        @(posedge clk); #1 lock_req = 1'b0;
    endtask

    task automatic pulse_stop();
        @(posedge clk); #1 wr_req = 1'b1;
        @(posedge clk); #1 wr_req = 1'b0;
    endtask

    task automatic send_write(input int pg, input int f, input int cnt,
                              input bit go, input string tag);
        int n;
        int nb;
        wr_page = 4'(pg); wr_first = 4'(f); wr_count = 5'(cnt);
        pulse_d0();
        repeat (2) @(posedge clk);
        #1 wr_req = 1'b1;
        if (go) begin
            nb = (cnt > 16) ? 16 : cnt;
            for (int i = 0; i < nb; i++) exp_q.push_back(eaddr(pg, f, i));
        end
        @(posedge clk); #1 wr_req = 1'b0;
        measure(n);
        chk({tag, " busy length"}, n, go ? CT : 0);
        chk({tag, " strobes outstanding"}, exp_q.size(), 0);
    endtask

    initial begin
        int n;
        // R12: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R12 busy", busy, 0);
        chk("R12 arr_we", arr_we, 0);
        chk("R12 cancel_flag", cancel_flag, 0);
        chk("R12 protect_set", protect_set, 0);
        chk("R12 lock_ack", lock_ack, 0);
        @(posedge clk); #1 rst = 1'b0;

        // R1, R2: single byte, then a wrapping multi-byte write
        send_write(3, 0, 1, 1'b1, "R1 single");
        send_write(9, 14, 5, 1'b1, "R2 wrap");
        // R3: over-long page keeps only PAGE_BYTES strobes
        send_write(2, 5, 20, 1'b1, "R3 rollover");

        // R6: pin high before the first data bit is ignored
        @(posedge clk); #1 wp_pin = 1'b1;
        repeat (3) @(posedge clk);
        #1 wp_pin = 1'b0;
        send_write(7, 2, 3, 1'b1, "R6 early pin");
        chk("R6 cancel_flag", cancel_flag, 0);

        // R4: pin high at the first-data-bit edge
        wr_page = 4'd6; wr_first = 4'd0; wr_count = 5'd2;
        @(posedge clk); #1 wp_pin = 1'b1;
        pulse_d0();
        wp_pin = 1'b0;
        pulse_stop();
        measure(n);
        chk("R4 pin at d0 busy", n, 0);
        chk("R4 pin at d0 cancel_flag", cancel_flag, 1);

        // R11: flag is sticky, then cleared by an accepted write
        repeat (10) @(posedge clk);
        @(negedge clk);
        chk("R11 sticky", cancel_flag, 1);
        wr_page = 4'd10; wr_first = 4'd0; wr_count = 5'd1;
        pulse_d0();
        @(posedge clk); #1 wr_req = 1'b1;
        exp_q.push_back(eaddr(10, 0, 0));
        @(posedge clk); #1 wr_req = 1'b0;
        @(negedge clk);
        chk("R11 cleared in first busy cycle", cancel_flag, 0);
        chk("R11 busy", busy, 1);
        measure(n);
        chk("R11 strobes outstanding", exp_q.size(), 0);

        // R4: pin high between the data bit and STOP
        wr_page = 4'd6; wr_first = 4'd1; wr_count = 5'd2;
        pulse_d0();
        wp_pin = 1'b1;
        @(posedge clk); #1 wp_pin = 1'b0;
        pulse_stop();
        measure(n);
        chk("R4 pin armed busy", n, 0);
        chk("R4 pin armed cancel_flag", cancel_flag, 1);

        // R5: pin during the program cycle, after four strobes
        wr_page = 4'd11; wr_first = 4'd3; wr_count = 5'd16;
        pulse_d0();
        @(posedge clk); #1 wr_req = 1'b1;
        for (int i = 0; i < 4; i++) exp_q.push_back(eaddr(11, 3, i));
        @(posedge clk); #1 wr_req = 1'b0;
        repeat (3) @(posedge clk);
        #1 wp_pin = 1'b1;
        @(negedge clk);
        chk("R5 busy before abort edge", busy, 1);
        @(negedge clk);
        chk("R5 busy after abort", busy, 0);
        chk("R5 cancel_flag", cancel_flag, 1);
        #1 wp_pin = 1'b0;
        repeat (3) @(negedge clk);
        chk("R5 no further strobes", exp_q.size(), 0);

        // R7: low supply drops the write and the protection command
        vcc_low = 1'b1;
        send_write(4, 1, 2, 1'b0, "R7 low supply");
        pulse_lock();
        @(negedge clk);
        chk("R7 lock not acked", ack_seen, 0);
        chk("R7 protect_set", protect_set, 0);
        vcc_low = 1'b0;

        // R10: commands inside a program cycle are ignored
        wr_page = 4'd5; wr_first = 4'd0; wr_count = 5'd2;
        pulse_d0();
        @(posedge clk); #1 wr_req = 1'b1;
        exp_q.push_back(eaddr(5, 0, 0));
        exp_q.push_back(eaddr(5, 0, 1));
        @(posedge clk); #1 wr_req = 1'b0;
        pulse_lock();
        wr_page = 4'd13;
        pulse_d0();
        pulse_stop();
        measure(n);
        chk("R10 busy remainder", n, CT - 6);
        repeat (2 * CT) @(negedge clk);
        chk("R10 no second cycle", busy, 0);
        chk("R10 lock ignored", ack_seen, 0);
        chk("R10 protect_set", protect_set, 0);
        chk("R10 strobes outstanding", exp_q.size(), 0);

        // R8: protection command, then boundary pages
        pulse_lock();
        @(negedge clk);
        chk("R8 lock_ack", lock_ack, 1);
        chk("R8 protect_set", protect_set, 1);
        @(negedge clk);
        chk("R8 lock_ack one cycle", lock_ack, 0);
        send_write(7, 0, 3, 1'b0, "R8 top lower page");
        send_write(0, 4, 1, 1'b0, "R8 bottom page");
        send_write(8, 15, 2, 1'b1, "R8 first upper page");

        // R9: second protection command
        pulse_lock();
        @(negedge clk);
        chk("R9 no second ack", lock_ack, 0);
        chk("R9 ack count", ack_seen, 1);
        chk("R9 protect_set kept", protect_set, 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule